// File: doc/BRIEF.md
# Exclusive Access Monitor

This block is the local reservation tracker for one processor port. It handles exclusive loads and exclusive stores and decides whether an exclusive store may write to memory. An exclusive load records a tag: its effective address, its access size and a valid bit. A later exclusive store writes only if that tag is still intact. The block then reports a status bit for the destination register: 0 when the write went ahead, 1 when it was refused.

Each request carries:
- an operation code;
- an access size;
- a base address;
- an optional word offset;
- write data.

The block forms the effective address and raises the memory write enable in the same cycle as the request. The tag is updated on the following clock edge. Two other inputs can destroy the reservation at any time:
- a snoop port that reports writes by other bus masters;
- a clear strobe.

Top module: `excl_mon_unit`

## Requirements
- R1: After reset the monitor holds no tag. An exclusive store (op code 1) issued before any exclusive load drives mem_we low, status_valid high and status 1.
- R2: An exclusive store whose effective address and size code equal those of the most recent exclusive load (op code 0) drives mem_we high, status_valid high and status 0, all in the cycle of the request.
- R3: An exclusive store whose effective address differs from the tagged address fails: mem_we low, status 1.
- R4: An exclusive store whose size code (0 byte, 1 halfword, 2 word) differs from the tagged size fails.
- R5: A snoop write whose address falls in the tagged granule (the address with its low GRAN_LG2 bits ignored) destroys the tag. This holds when the snoop arrives between the load and the store, in the same cycle as the store, or in the same cycle as the load. The exclusive store then fails.
- R6: Every legal exclusive store opens the monitor, whether it passes or fails. A second exclusive store to the same address then fails.
- R7: The clear strobe opens the monitor. When it is raised in the same cycle as an exclusive store, that store fails.
- R8: For size code 2 with the offset flag set, the effective address is base plus offset. Without the flag it is the base. For byte and halfword sizes it is the base, and the offset is ignored.
- R9: A request is rejected as illegal when any of these holds: a word offset that is not a multiple of 4, a word offset above 1020, size code 3, or op code 3. A rejected request raises illegal, keeps mem_we and status_valid low, and leaves the monitor unchanged.
- R10: An ordinary store (op code 2) drives mem_we high and status_valid low, and does not disturb the tag.
- R11: A new exclusive load replaces the tag. Only a store matching the latest load passes.
- R12: A snoop write outside the tagged granule leaves the tag intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 exclusive load, 1 exclusive store, 2 ordinary store, 3 illegal |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_base | input | AW | Base address |
| req_offset | input | OFFW | Word offset value |
| req_has_off | input | 1 | Offset present |
| req_wdata | input | DW | Store data |
| snoop_valid | input | 1 | Write by another master observed |
| snoop_addr | input | AW | Address of that write |
| clrex | input | 1 | Clear the reservation |
| eff_addr | output | AW | Effective address of the request |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DW | Data to memory |
| status_valid | output | 1 | Status is produced this cycle (exclusive store) |
| status | output | 1 | 0 stored, 1 refused |
| illegal | output | 1 | Request rejected as illegal |

## Verification
The bench builds the block with its defaults:
- AW = 32 and DW = 32;
- OFFW = 11, so offsets above the 1020 limit (for example 1024) can be driven;
- GRAN_LG2 = 2, so the granule-based snoop comparator variant is built rather than the exact-match one.

Together these let the bench exercise the offset range boundary and a snoop that lands on a different byte of the tagged word.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
   typedef enum logic [1:0] {
      OP_LDX = 2'd0,
      OP_STX = 2'd1,
      OP_ST  = 2'd2,
      OP_BAD = 2'd3
   } xop_e;

   typedef enum logic [1:0] {
      SZ_B   = 2'd0,
      SZ_H   = 2'd1,
      SZ_W   = 2'd2,
      SZ_BAD = 2'd3
   } xsz_e;
endpackage

// File: rtl/excl_gran_cmp.sv
module excl_gran_cmp #(
   parameter int AW       = 32,
   parameter int GRAN_LG2 = 2
) (
   input  logic [AW-1:0] a_i,
   input  logic [AW-1:0] b_i,
   output logic          eq_o
);
   generate
      if (GRAN_LG2 == 0) begin : g_exact
         assign eq_o = (a_i == b_i);
      end else begin : g_gran
         assign eq_o = (a_i[AW-1:GRAN_LG2] == b_i[AW-1:GRAN_LG2]);
      end
   endgenerate
endmodule

// File: rtl/excl_addr_gen.sv
module excl_addr_gen
   import excl_mon_pkg::*;
#(
   parameter int AW      = 32,
   parameter int OFFW    = 11,
   parameter int MAX_OFF = 1020
) (
   input  logic            valid_i,
   input  logic [1:0]      op_i,
   input  logic [1:0]      size_i,
   input  logic [AW-1:0]   base_i,
   input  logic [OFFW-1:0] off_i,
   input  logic            has_off_i,
   output logic [AW-1:0]   eff_o,
   output logic            illegal_o
);
   localparam int ALIGN_LG2 = 2;
   localparam logic [OFFW-1:0] OFF_LIMIT = OFFW'(MAX_OFF);

   logic            word_off;
   logic            off_ok;
   logic [AW-1:0]   off_ext;

   assign word_off = has_off_i && (size_i == SZ_W);
   assign off_ok   = (off_i[ALIGN_LG2-1:0] == '0) && (off_i <= OFF_LIMIT);
   assign off_ext  = {{(AW-OFFW){1'b0}}, off_i};

   always_comb begin
      eff_o = base_i;
      if (word_off) eff_o = base_i + off_ext;
   end

   always_comb begin
      illegal_o = 1'b0;
      if (valid_i) begin
         if (size_i == SZ_BAD)        illegal_o = 1'b1;
         if (op_i == OP_BAD)          illegal_o = 1'b1;
         if (word_off && !off_ok)     illegal_o = 1'b1;
      end
   end
endmodule

// File: rtl/excl_tag_store.sv
module excl_tag_store #(
   parameter int AW       = 32,
   parameter int GRAN_LG2 = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ldx_i,
   input  logic          stx_i,
   input  logic          clrex_i,
   input  logic [AW-1:0] set_addr_i,
   input  logic [1:0]    set_size_i,
   input  logic          snoop_valid_i,
   input  logic [AW-1:0] snoop_addr_i,
   output logic          tag_valid_o,
   output logic [AW-1:0] tag_addr_o,
   output logic [1:0]    tag_size_o,
   output logic          kill_o
);
   logic snp_eq_tag;
   logic snp_eq_new;
   logic hit_tag;
   logic hit_new;

   excl_gran_cmp #(.AW(AW), .GRAN_LG2(GRAN_LG2)) u_cmp_tag (
      .a_i (snoop_addr_i),
      .b_i (tag_addr_o),
      .eq_o(snp_eq_tag)
   );

   excl_gran_cmp #(.AW(AW), .GRAN_LG2(GRAN_LG2)) u_cmp_new (
      .a_i (snoop_addr_i),
      .b_i (set_addr_i),
      .eq_o(snp_eq_new)
   );

   assign hit_tag = snoop_valid_i && tag_valid_o && snp_eq_tag;
   assign hit_new = snoop_valid_i && snp_eq_new;
   assign kill_o  = clrex_i || hit_tag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_valid_o <= 1'b0;
         tag_addr_o  <= '0;
         tag_size_o  <= '0;
      end else if (ldx_i) begin
         tag_valid_o <= !(clrex_i || hit_new);
         tag_addr_o  <= set_addr_i;
         tag_size_o  <= set_size_i;
      end else if (stx_i || kill_o) begin
         tag_valid_o <= 1'b0;
      end
   end

   AST_STX_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      stx_i |=> !tag_valid_o); // R6
   AST_CLREX_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      clrex_i |=> !tag_valid_o); // R7
   AST_SNOOP_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_valid_i && tag_valid_o && snp_eq_tag && !ldx_i) |=> !tag_valid_o); // R5
   AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ldx_i && !stx_i && !clrex_i && !snoop_valid_i)
         |=> ($stable(tag_valid_o) && $stable(tag_addr_o) && $stable(tag_size_o))); // R10
endmodule

// File: rtl/excl_mon_unit.sv
module excl_mon_unit
   import excl_mon_pkg::*;
#(
   parameter int AW       = 32,
   parameter int DW       = 32,
   parameter int OFFW     = 11,
   parameter int MAX_OFF  = 1020,
   parameter int GRAN_LG2 = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [1:0]      req_op,
   input  logic [1:0]      req_size,
   input  logic [AW-1:0]   req_base,
   input  logic [OFFW-1:0] req_offset,
   input  logic            req_has_off,
   input  logic [DW-1:0]   req_wdata,
   input  logic            snoop_valid,
   input  logic [AW-1:0]   snoop_addr,
   input  logic            clrex,
   output logic [AW-1:0]   eff_addr,
   output logic            mem_we,
   output logic [DW-1:0]   mem_wdata,
   output logic            status_valid,
   output logic            status,
   output logic            illegal
);
   generate
      if (OFFW >= AW) begin : g_bad_offw
         $error("OFFW must be narrower than AW");
      end
      if (MAX_OFF >= (1 << OFFW)) begin : g_bad_max
         $error("MAX_OFF does not fit in OFFW bits");
      end
      if (GRAN_LG2 >= AW || GRAN_LG2 < 0) begin : g_bad_gran
         $error("GRAN_LG2 out of range");
      end
   endgenerate

   logic            ok;
   logic            is_ldx;
   logic            is_stx;
   logic            is_st;
   logic            tag_valid;
   logic [AW-1:0]   tag_addr;
   logic [1:0]      tag_size;
   logic            kill;
   logic            pass;

   excl_addr_gen #(.AW(AW), .OFFW(OFFW), .MAX_OFF(MAX_OFF)) u_agen (
      .valid_i  (req_valid),
      .op_i     (req_op),
      .size_i   (req_size),
      .base_i   (req_base),
      .off_i    (req_offset),
      .has_off_i(req_has_off),
      .eff_o    (eff_addr),
      .illegal_o(illegal)
   );

   assign ok     = req_valid && !illegal;
   assign is_ldx = ok && (req_op == OP_LDX);
   assign is_stx = ok && (req_op == OP_STX);
   assign is_st  = ok && (req_op == OP_ST);

   excl_tag_store #(.AW(AW), .GRAN_LG2(GRAN_LG2)) u_tags (
      .clk          (clk),
      .rst_n        (rst_n),
      .ldx_i        (is_ldx),
      .stx_i        (is_stx),
      .clrex_i      (clrex),
      .set_addr_i   (eff_addr),
      .set_size_i   (req_size),
      .snoop_valid_i(snoop_valid),
      .snoop_addr_i (snoop_addr),
      .tag_valid_o  (tag_valid),
      .tag_addr_o   (tag_addr),
      .tag_size_o   (tag_size),
      .kill_o       (kill)
   );

   assign pass = is_stx && tag_valid && !kill
                 && (tag_addr == eff_addr) && (tag_size == req_size);

   assign mem_we       = pass || is_st;
   assign mem_wdata    = req_wdata;
   assign status_valid = is_stx;
   assign status       = is_stx && !pass;

   AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!mem_we && !status_valid)); // R9
   AST_PASS_NEEDS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      (status_valid && !status) |-> tag_valid); // R2
   AST_ILLEGAL_KEEPS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      (illegal && !clrex && !snoop_valid) |=> ($stable(tag_valid) && $stable(tag_addr))); // R9
endmodule

// File: tb/excl_mon_unit_tb.sv
`timescale 1ns/1ps
module excl_mon_unit_tb_top;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int OFFW = 11;

   typedef struct packed {
      logic            v;
      logic [1:0]      op;
      logic [1:0]      sz;
      logic [AW-1:0]   base;
      logic [OFFW-1:0] off;
      logic            ho;
      logic            sv;
      logic [AW-1:0]   sa;
      logic            clr;
      logic            we;
      logic            stv;
      logic            st;
      logic            ill;
      logic [AW-1:0]   addr;
   } vec_t;

   localparam int NV = 43;
   // op: 0 LDX 1 STX 2 ST 3 bad; size: 0 B 1 H 2 W
   localparam vec_t VECS [0:NV-1] = '{
      '{1'b1,2'd1,2'd2,32'h100,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b1,1'b1,1'b0,32'h100},      // R1
      '{1'b1,2'd0,2'd2,32'h100,11'd8,1'b1,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h108},      // R8
      '{1'b1,2'd1,2'd2,32'h100,11'd8,1'b1,1'b0,32'h0,1'b0,1'b1,1'b1,1'b0,1'b0,32'h108},      // R2
      '{1'b1,2'd1,2'd2,32'h108,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b1,1'b1,1'b0,32'h108},      // R6
      '{1'b1,2'd0,2'd1,32'h200,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h200},
      '{1'b1,2'd1,2'd0,32'h200,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b1,1'b1,1'b0,32'h200},      // R4
      '{1'b1,2'd0,2'd0,32'h301,11'd16,1'b1,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h301},     // R8
      '{1'b1,2'd1,2'd0,32'h302,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b1,1'b1,1'b0,32'h302},      // R3
      '{1'b1,2'd0,2'd2,32'h400,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h400},
      '{1'b0,2'd0,2'd0,32'h0,11'd0,1'b0,1'b1,32'h404,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0},        // R12
      '{1'b1,2'd1,2'd2,32'h400,11'd0,1'b0,1'b0,32'h0,1'b0,1'b1,1'b1,1'b0,1'b0,32'h400},      // R12
      '{1'b1,2'd0,2'd2,32'h400,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h400},
      '{1'b0,2'd0,2'd0,32'h0,11'd0,1'b0,1'b1,32'h402,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0},        // R5
      '{1'b1,2'd1,2'd2,32'h400,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b1,1'b1,1'b0,32'h400},      // R5
      '{1'b1,2'd0,2'd2,32'h500,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h500},
      '{1'b1,2'd1,2'd2,32'h500,11'd0,1'b0,1'b1,32'h500,1'b0,1'b0,1'b1,1'b1,1'b0,32'h500},    // R5
      '{1'b1,2'd0,2'd2,32'h600,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h600},
      '{1'b0,2'd0,2'd0,32'h0,11'd0,1'b0,1'b0,32'h0,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0},          // R7
      '{1'b1,2'd1,2'd2,32'h600,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b1,1'b1,1'b0,32'h600},      // R7
      '{1'b1,2'd0,2'd2,32'h700,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h700},
      '{1'b1,2'd1,2'd2,32'h700,11'd0,1'b0,1'b0,32'h0,1'b1,1'b0,1'b1,1'b1,1'b0,32'h700},      // R7
      '{1'b1,2'd0,2'd2,32'h800,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h800},
      '{1'b1,2'd2,2'd2,32'h800,11'd0,1'b0,1'b0,32'h0,1'b0,1'b1,1'b0,1'b0,1'b0,32'h800},      // R10
      '{1'b1,2'd1,2'd2,32'h800,11'd0,1'b0,1'b0,32'h0,1'b0,1'b1,1'b1,1'b0,1'b0,32'h800},      // R10
      '{1'b1,2'd0,2'd2,32'h900,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h900},
      '{1'b1,2'd0,2'd2,32'hA00,11'd6,1'b1,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b1,32'hA06},      // R9
      '{1'b1,2'd0,2'd2,32'hA00,11'd1024,1'b1,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b1,32'hE00},   // R9
      '{1'b1,2'd0,2'd3,32'hA00,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b1,32'hA00},      // R9
      '{1'b1,2'd1,2'd2,32'h900,11'd0,1'b0,1'b0,32'h0,1'b0,1'b1,1'b1,1'b0,1'b0,32'h900},      // R9
      '{1'b1,2'd0,2'd2,32'hB00,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b0,32'hB00},
      '{1'b1,2'd0,2'd2,32'hC00,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b0,32'hC00},
      '{1'b1,2'd1,2'd2,32'hC00,11'd0,1'b0,1'b0,32'h0,1'b0,1'b1,1'b1,1'b0,1'b0,32'hC00},      // R11
      '{1'b1,2'd0,2'd2,32'hB00,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b0,32'hB00},
      '{1'b1,2'd0,2'd2,32'hC00,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b0,32'hC00},
      '{1'b1,2'd1,2'd2,32'hB00,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b1,1'b1,1'b0,32'hB00},      // R11
      '{1'b1,2'd0,2'd2,32'hD00,11'd1020,1'b1,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b0,32'h10FC},  // R8
      '{1'b1,2'd1,2'd2,32'hD00,11'd1020,1'b1,1'b0,32'h0,1'b0,1'b1,1'b1,1'b0,1'b0,32'h10FC},  // R8
      '{1'b1,2'd3,2'd2,32'h0,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b1,32'h0},          // R9
      '{1'b1,2'd0,2'd2,32'hE00,11'd0,1'b0,1'b1,32'hE00,1'b0,1'b0,1'b0,1'b0,1'b0,32'hE00},    // R5
      '{1'b1,2'd1,2'd2,32'hE00,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b1,1'b1,1'b0,32'hE00},      // R5
      '{1'b1,2'd0,2'd2,32'hF00,11'd0,1'b0,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b0,32'hF00},
      '{1'b1,2'd1,2'd2,32'hF00,11'd2,1'b1,1'b0,32'h0,1'b0,1'b0,1'b0,1'b0,1'b1,32'hF02},      // R9
      '{1'b1,2'd1,2'd2,32'hF00,11'd0,1'b0,1'b0,32'h0,1'b0,1'b1,1'b1,1'b0,1'b0,32'hF00}       // R9
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [1:0]      req_op = 2'd0;
   logic [1:0]      req_size = 2'd0;
   logic [AW-1:0]   req_base = '0;
   logic [OFFW-1:0] req_offset = '0;
   logic            req_has_off = 1'b0;
   logic [DW-1:0]   req_wdata = 32'hCAFE_0001;
   logic            snoop_valid = 1'b0;
   logic [AW-1:0]   snoop_addr = '0;
   logic            clrex = 1'b0;
   logic [AW-1:0]   eff_addr;
   logic            mem_we;
   logic [DW-1:0]   mem_wdata;
   logic            status_valid;
   logic            status;
   logic            illegal;

   int n_checks = 0;
   int n_fails  = 0;

   always #2.5 clk = ~clk;

   excl_mon_unit dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_size(req_size), .req_base(req_base), .req_offset(req_offset),
      .req_has_off(req_has_off), .req_wdata(req_wdata), .snoop_valid(snoop_valid),
      .snoop_addr(snoop_addr), .clrex(clrex), .eff_addr(eff_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .status_valid(status_valid), .status(status),
      .illegal(illegal)
   );

   task automatic drive(input vec_t t);
      @(negedge clk);
      req_valid   = t.v;
      req_op      = t.op;
      req_size    = t.sz;
      req_base    = t.base;
      req_offset  = t.off;
      req_has_off = t.ho;
      snoop_valid = t.sv;
      snoop_addr  = t.sa;
      clrex       = t.clr;
      #1;
   endtask

   task automatic check(input string tag, input logic [AW+3:0] got, input logic [AW+3:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got we/stv/st/ill/addr=%h expected %h", tag, got, exp);
      end
   endtask

   task automatic idle();
      vec_t t;
      t = '0;
      drive(t);
   endtask

   initial begin
      #100000;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      vec_t t;
      repeat (3) @(posedge clk);
      #1;
      // R1: outputs quiet in reset
      check("R1 reset", {mem_we, status_valid, status, illegal, eff_addr}, {4'b0000, 32'h0});
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         check($sformatf("vector %0d", i),
               {mem_we, status_valid, status, illegal, eff_addr},
               {VECS[i].we, VECS[i].stv, VECS[i].st, VECS[i].ill, VECS[i].addr});
      end

      // R10: write data forwarded with an ordinary store
      t = '0; t.v = 1'b1; t.op = 2'd2; t.sz = 2'd2; t.base = 32'h40;
      drive(t);
      check("R10 wdata", {4'b0, mem_wdata}, {4'b0, 32'hCAFE_0001});

      // R1: reset drops a live tag
      t = '0; t.v = 1'b1; t.op = 2'd0; t.sz = 2'd2; t.base = 32'h40;
      drive(t);
      @(negedge clk);
      rst_n = 1'b0;
      idle();
      @(negedge clk);
      rst_n = 1'b1;
      t.op = 2'd1;
      drive(t);
      check("R1 after reset", {mem_we, status_valid, status, illegal, eff_addr},
            {4'b0110, 32'h40});

      // R2: halfword exclusive pair passes
      t = '0; t.v = 1'b1; t.op = 2'd0; t.sz = 2'd1; t.base = 32'h82;
      drive(t);
      t.op = 2'd1;
      drive(t);
      check("R2 halfword", {mem_we, status_valid, status, illegal, eff_addr},
            {4'b1100, 32'h82});

      idle();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule